// File: doc/BRIEF.md
# Mask-driven call and return frame sequencer

This block performs the stack side of a procedure call and of its matching return. The caller has already pushed its argument words below the stack pointer. A call request then supplies the argument count, the target address, the save mask fetched from the target's first word and the current status word. The sequencer writes one word per cycle to a stack memory port and then updates its argument, frame, stack and program-counter registers. A return request reads the frame back one word per cycle, writes the saved general registers and the status word back out, and restores the four pointer registers.

The mask is a run-time value, so the frame size varies from call to call. The mask is stored in the frame beside the status word. The return reads it back first, so it restores exactly the registers that the call saved. Register 0 is never saved or restored, which leaves it free to carry a result.

Top module: `callret_seq`

## Requirements
- R1: After reset SP, FP and AP equal SP_INIT (0x100), PC equals PC_INIT (0x1000) and busy is low. While busy is low, no memory, register or status write or read is issued.
- R2: One cycle after a call is accepted, the argument count is written, zero-extended, to address SP-4. Every following call write goes to the address 4 below the previous one, one write per cycle.
- R3: After the count word, each general register whose mask bit (bits 11..1) is set is written, highest index first. Registers whose bit is clear are skipped and take no cycle. Mask bit 0 has no effect: register 0 is never pushed and never written back.
- R4: After the registers, the call writes the old PC, the old FP and the old AP. Its last write is one word holding the mask in bits 27:16 and the status word in bits 15:0, with bits 31:28 zero.
- R5: A call keeps busy high for 5+n cycles, where n is the number of registers it saves. In the cycle after its last write, AP equals the old SP-4, FP and SP both equal the address of the last write, and PC equals the target plus 2.
- R6: A return reads from FP upward, 4 bytes per cycle. It reads the mask/status word first, then the saved AP, FP and PC, then the saved registers, lowest index first. During the first read it pulses the status write port with bits 15:0 of the word read.
- R7: After a return, AP, FP and PC equal the values they had before the matching call, and SP equals AP+4 as it was before the return, which is the stack pointer from before the call. Each selected register receives its saved value. Registers that were not selected, and register 0, keep the values they had before the return.
- R8: A call or return request seen while busy is ignored. When both requests arrive together while idle, the call is taken.
- R9: A mask of 0x040 saves only register 6, giving a six-word frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_go | input | 1 | Start a call (taken when idle) |
| ret_go | input | 1 | Start a return (taken when idle, no call) |
| narg | input | 8 | Argument word count for the call |
| target | input | 32 | Callee entry address |
| mask_in | input | 12 | Save mask fetched from the callee entry |
| psw_in | input | 16 | Current status word |
| gpr_in | input | 384 | General registers, register i in bits 32i+31:32i |
| mem_we | output | 1 | Stack write strobe |
| mem_re | output | 1 | Stack read strobe |
| mem_addr | output | 32 | Stack byte address |
| mem_wdata | output | 32 | Stack write data |
| mem_rdata | input | 32 | Stack read data, same cycle as the address |
| gpr_we | output | 1 | General register write strobe (return) |
| gpr_waddr | output | 4 | General register write index |
| gpr_wdata | output | 32 | General register write data |
| psw_we | output | 1 | Status word write strobe (return) |
| psw_wdata | output | 16 | Restored status word |
| ap | output | 32 | Argument pointer |
| fp | output | 32 | Frame pointer |
| sp | output | 32 | Stack pointer |
| pc | output | 32 | Program counter |
| busy | output | 1 | Sequence in progress |

## Verification
Calls are tried with a mask that selects only register 6, with a full mask that includes bit 0, with an empty mask and with a sparse mask. These show whether the frame length, the push order, the skipping of clear bits and the exclusion of register 0 follow the mask. Three calls are nested and then unwound in reverse order, with every register overwritten between steps. This separates a return that restores from its own frame from one that reuses stale pointer values, and it shows which registers a return writes. Requests raised during a busy sequence, and both requests raised together, check that the call order is not disturbed.

// File: rtl/callret_seq.sv
module callret_seq #(
  parameter int DW = 32,
  parameter int NREG = 12,
  parameter int CW = 8,
  parameter int PW = 16,
  parameter logic [DW-1:0] SP_INIT = 32'h0000_0100,
  parameter logic [DW-1:0] PC_INIT = 32'h0000_1000,
  localparam int IW = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               call_go,
  input  logic               ret_go,
  input  logic [CW-1:0]      narg,
  input  logic [DW-1:0]      target,
  input  logic [NREG-1:0]    mask_in,
  input  logic [PW-1:0]      psw_in,
  input  logic [NREG*DW-1:0] gpr_in,
  output logic               mem_we,
  output logic               mem_re,
  output logic [DW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic [DW-1:0]      mem_rdata,
  output logic               gpr_we,
  output logic [IW-1:0]      gpr_waddr,
  output logic [DW-1:0]      gpr_wdata,
  output logic               psw_we,
  output logic [PW-1:0]      psw_wdata,
  output logic [DW-1:0]      ap,
  output logic [DW-1:0]      fp,
  output logic [DW-1:0]      sp,
  output logic [DW-1:0]      pc,
  output logic               busy
);
  localparam logic [DW-1:0] STEP = DW'(4);
  localparam logic [NREG-1:0] KEEP = ~NREG'(1);

  typedef enum logic [3:0] {
    IDLE, C_ARGC, C_REGS, C_PC, C_FP, C_AP, C_MSK,
    R_MSK, R_AP, R_FP, R_PC, R_REGS
  } st_t;

  st_t             st;
  logic [DW-1:0]   wp, ap_q, fp_q, sp_q, pc_q, tgt_q;
  logic [NREG-1:0] pend, msk_q;
  logic [CW-1:0]   cnt_q;
  logic [PW-1:0]   psw_q;
  logic [IW-1:0]   hi, lo;
  logic            last;

  always_comb begin
    hi = '0;
    for (int i = 0; i < NREG; i++) if (pend[i]) hi = IW'(i);
    lo = '0;
    for (int i = NREG - 1; i >= 0; i--) if (pend[i]) lo = IW'(i);
  end

  assign last = (pend & (pend - 1'b1)) == '0;

  assign busy     = st != IDLE;
  assign mem_we   = st inside {C_ARGC, C_REGS, C_PC, C_FP, C_AP, C_MSK};
  assign mem_re   = st inside {R_MSK, R_AP, R_FP, R_PC, R_REGS};
  assign mem_addr = wp;

  always_comb begin
    case (st)
      C_ARGC:  mem_wdata = DW'(cnt_q);
      C_REGS:  mem_wdata = gpr_in[hi*DW +: DW];
      C_PC:    mem_wdata = pc_q;
      C_FP:    mem_wdata = fp_q;
      C_AP:    mem_wdata = ap_q;
      C_MSK:   mem_wdata = DW'({msk_q, psw_q});
      default: mem_wdata = '0;
    endcase
  end

  assign gpr_we    = st == R_REGS;
  assign gpr_waddr = lo;
  assign gpr_wdata = mem_rdata;
  assign psw_we    = st == R_MSK;
  assign psw_wdata = mem_rdata[PW-1:0];

  assign ap = ap_q;
  assign fp = fp_q;
  assign sp = sp_q;
  assign pc = pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= IDLE;
      wp    <= '0;
      pend  <= '0;
      msk_q <= '0;
      cnt_q <= '0;
      psw_q <= '0;
      tgt_q <= '0;
      ap_q  <= SP_INIT;
      fp_q  <= SP_INIT;
      sp_q  <= SP_INIT;
      pc_q  <= PC_INIT;
    end else begin
      case (st)
        IDLE: begin
          if (call_go) begin
            st    <= C_ARGC;
            wp    <= sp_q - STEP;
            pend  <= mask_in & KEEP;
            msk_q <= mask_in;
            cnt_q <= narg;
            psw_q <= psw_in;
            tgt_q <= target;
          end else if (ret_go) begin
            st <= R_MSK;
            wp <= fp_q;
          end
        end
        C_ARGC: begin
          wp <= wp - STEP;
          st <= (pend != '0) ? C_REGS : C_PC;
        end
        C_REGS: begin
          wp       <= wp - STEP;
          pend[hi] <= 1'b0;
          if (last) st <= C_PC;
        end
        C_PC: begin
          wp <= wp - STEP;
          st <= C_FP;
        end
        C_FP: begin
          wp <= wp - STEP;
          st <= C_AP;
        end
        C_AP: begin
          wp <= wp - STEP;
          st <= C_MSK;
        end
        C_MSK: begin
          ap_q <= sp_q - STEP;
          fp_q <= wp;
          sp_q <= wp;
          pc_q <= tgt_q + DW'(2);
          st   <= IDLE;
        end
        R_MSK: begin
          wp   <= wp + STEP;
          pend <= mem_rdata[PW +: NREG] & KEEP;
          sp_q <= ap_q + STEP;
          st   <= R_AP;
        end
        R_AP: begin
          wp   <= wp + STEP;
          ap_q <= mem_rdata;
          st   <= R_FP;
        end
        R_FP: begin
          wp   <= wp + STEP;
          fp_q <= mem_rdata;
          st   <= R_PC;
        end
        R_PC: begin
          wp   <= wp + STEP;
          pc_q <= mem_rdata;
          st   <= (pend != '0) ? R_REGS : IDLE;
        end
        R_REGS: begin
          wp       <= wp + STEP;
          pend[lo] <= 1'b0;
          if (last) st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/callret_seq_chk.sv
module callret_seq_chk #(
  parameter int DW = 32,
  parameter int NREG = 12,
  localparam int IW = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          mem_we,
  input logic          mem_re,
  input logic [DW-1:0] mem_addr,
  input logic          gpr_we,
  input logic [IW-1:0] gpr_waddr,
  input logic          psw_we,
  input logic [DW-1:0] sp,
  input logic [DW-1:0] fp
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we && !mem_re && !gpr_we && !psw_we);

  // R2
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && $past(mem_we) |-> mem_addr == $past(mem_addr) - DW'(4));

  // R3
  no_r0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gpr_we |-> gpr_waddr != '0);

  // R5
  call_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && $past(mem_we) |-> sp == fp);

  // R6
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re && $past(mem_re) |-> mem_addr == $past(mem_addr) + DW'(4));

  // R6
  psw_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psw_we |=> !psw_we);
endmodule

bind callret_seq callret_seq_chk #(.DW(DW), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_we(mem_we), .mem_re(mem_re),
  .mem_addr(mem_addr), .gpr_we(gpr_we), .gpr_waddr(gpr_waddr),
  .psw_we(psw_we), .sp(sp), .fp(fp)
);

// File: tb/callret_seq_bench.sv
`timescale 1ns/1ps
module callret_seq_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic call_go, ret_go;
  logic [7:0] narg;
  logic [31:0] target;
  logic [11:0] mask_in;
  logic [15:0] psw_in;
  logic [383:0] gpr_in;
  logic mem_we, mem_re;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic gpr_we;
  logic [3:0] gpr_waddr;
  logic [31:0] gpr_wdata;
  logic psw_we;
  logic [15:0] psw_wdata;
  logic [31:0] ap, fp, sp, pc;
  logic busy;

  always #2.5 clk = ~clk;

  callret_seq u_callret_seq (
    .clk(clk), .rst_n(rst_n), .call_go(call_go), .ret_go(ret_go), .narg(narg),
    .target(target), .mask_in(mask_in), .psw_in(psw_in), .gpr_in(gpr_in),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .gpr_we(gpr_we), .gpr_waddr(gpr_waddr),
    .gpr_wdata(gpr_wdata), .psw_we(psw_we), .psw_wdata(psw_wdata),
    .ap(ap), .fp(fp), .sp(sp), .pc(pc), .busy(busy)
  );

  logic [31:0] mem [64];
  logic [31:0] rf [12];
  logic [15:0] psw_m;
  logic [31:0] m_ap, m_fp, m_sp, m_pc;
  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct packed {
    logic [11:0] mask;
    logic [15:0] psw;
    logic [31:0] ap, fp, pc, sp;
    logic [383:0] regs;
  } frame_t;
  frame_t frames[$];

  assign mem_rdata = mem[mem_addr[7:2]];
  always_comb for (int i = 0; i < 12; i++) gpr_in[i*32 +: 32] = rf[i];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic clobber(input logic [31:0] seed);
    for (int i = 0; i < 12; i++) rf[i] = seed + 32'(i);
  endtask

  task automatic do_call(input logic [7:0] n, input logic [31:0] t, input logic [11:0] m,
                         input logic [15:0] p, input bit both, input bit poke);
    logic [31:0] qa[$], qd[$];
    logic [31:0] w;
    frame_t fr;
    w = m_sp - 4;
    qa.push_back(w); qd.push_back({24'h0, n}); w -= 4;
    for (int i = 11; i >= 1; i--)
      if (m[i]) begin qa.push_back(w); qd.push_back(rf[i]); w -= 4; end
    qa.push_back(w); qd.push_back(m_pc); w -= 4;
    qa.push_back(w); qd.push_back(m_fp); w -= 4;
    qa.push_back(w); qd.push_back(m_ap); w -= 4;
    qa.push_back(w); qd.push_back({4'h0, m, p});
    fr.mask = m; fr.psw = p; fr.ap = m_ap; fr.fp = m_fp; fr.pc = m_pc; fr.sp = m_sp;
    for (int i = 0; i < 12; i++) fr.regs[i*32 +: 32] = rf[i];
    frames.push_back(fr);
    call_go = 1; ret_go = both; narg = n; target = t; mask_in = m; psw_in = p;
    @(posedge clk); @(negedge clk);
    call_go = 0; ret_go = 0;
    for (int k = 0; k < qa.size(); k++) begin
      ret_go = (poke && k == 2);
      // R2 R3 R4 R8: each cycle is the next expected push
      chk("R2 push strobe", {30'h0, mem_we, mem_re}, 32'h2);
      chk("R5 busy during call", {31'h0, busy}, 32'h1);
      chk("R2 push address", mem_addr, qa[k]);
      chk(k == 0 ? "R2 count word" : (k < qa.size() - 4 ? "R3 saved register" : "R4 frame word"),
          mem_wdata, qd[k]);
      mem[mem_addr[7:2]] = mem_wdata;
      @(posedge clk); @(negedge clk);
    end
    ret_go = 0;
    m_ap = m_sp - 4; m_fp = qa[qa.size()-1]; m_sp = m_fp; m_pc = t + 2;
    // R5
    chk("R5 busy end", {31'h0, busy}, 32'h0);
    chk("R5 AP", ap, m_ap);
    chk("R5 FP", fp, m_fp);
    chk("R5 SP", sp, m_sp);
    chk("R5 PC", pc, m_pc);
  endtask

  task automatic do_ret();
    frame_t fr;
    logic [31:0] pre [12];
    int idx[$];
    fr = frames.pop_back();
    for (int i = 0; i < 12; i++) pre[i] = rf[i];
    for (int i = 1; i < 12; i++) if (fr.mask[i]) idx.push_back(i);
    ret_go = 1;
    @(posedge clk); @(negedge clk);
    ret_go = 0;
    for (int k = 0; k < 4 + idx.size(); k++) begin
      // R6
      chk("R6 read strobe", {30'h0, mem_we, mem_re}, 32'h1);
      chk("R6 read address", mem_addr, m_fp + 32'(4 * k));
      chk("R6 status pulse", {31'h0, psw_we}, {31'h0, k == 0});
      if (k == 0) begin
        chk("R6 status value", {16'h0, psw_wdata}, {16'h0, fr.psw});
        psw_m = psw_wdata;
      end
      if (k >= 4) begin
        // R7
        chk("R7 reg write", {31'h0, gpr_we}, 32'h1);
        chk("R7 reg index", {28'h0, gpr_waddr}, 32'(idx[k-4]));
        rf[gpr_waddr] = gpr_wdata;
      end else begin
        chk("R7 no reg write", {31'h0, gpr_we}, 32'h0);
      end
      @(posedge clk); @(negedge clk);
    end
    m_sp = m_ap + 4; m_ap = fr.ap; m_fp = fr.fp; m_pc = fr.pc;
    chk("R7 busy end", {31'h0, busy}, 32'h0);
    chk("R7 SP", sp, fr.sp);
    chk("R7 SP model", sp, m_sp);
    chk("R7 AP", ap, fr.ap);
    chk("R7 FP", fp, fr.fp);
    chk("R7 PC", pc, fr.pc);
    chk("R7 status", {16'h0, psw_m}, {16'h0, fr.psw});
    for (int i = 0; i < 12; i++)
      chk(i == 0 ? "R3 R0 untouched" : "R7 register",
          rf[i], (i != 0 && fr.mask[i]) ? fr.regs[i*32 +: 32] : pre[i]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst_n = 0; call_go = 0; ret_go = 0; narg = 0; target = 0; mask_in = 0; psw_in = 0;
    psw_m = 0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    for (int i = 0; i < 12; i++) rf[i] = 32'hA000_0000 + 32'(i * 32'h111);
    m_ap = 32'h100; m_fp = 32'h100; m_sp = 32'h100; m_pc = 32'h1000;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 SP", sp, 32'h100);
    chk("R1 FP", fp, 32'h100);
    chk("R1 AP", ap, 32'h100);
    chk("R1 PC", pc, 32'h1000);
    chk("R1 busy", {31'h0, busy}, 32'h0);
    chk("R1 idle port", {29'h0, mem_we, mem_re, gpr_we}, 32'h0);
    // R9: only register 6
    do_call(8'd1, 32'h2000, 12'h040, 16'h0009, 0, 0);
    chk("R9 frame depth", 32'h100 - sp, 32'd24);
    clobber(32'hB000_0000);
    // R3 full mask incl. bit 0, R8 request while busy
    do_call(8'd3, 32'h3000, 12'hFFF, 16'h00F1, 0, 1);
    clobber(32'hC000_0000);
    // R8 both requests: call wins; empty mask
    do_call(8'd0, 32'h4000, 12'h000, 16'h1234, 1, 0);
    clobber(32'hD000_0000);
    rf[0] = 32'hDEAD_BEEF;
    do_ret();
    repeat (2) begin
      @(negedge clk);
      chk("R1 idle quiet", {29'h0, mem_we, mem_re, gpr_we}, 32'h0);
    end
    do_ret();
    clobber(32'hE000_0000);
    do_call(8'd2, 32'h5000, 12'hA52, 16'h0777, 0, 0);
    clobber(32'hF000_0000);
    do_ret();
    do_ret();
    chk("R7 back to start SP", sp, 32'h100);
    finish_up();
  end
endmodule